// File: doc/BRIEF.md
# Glitch-Hardened One-Hot Handshake Stage

This block is one register stage on a delay-insensitive point-to-point link. It is modelled with a sampling clock. Each 2-bit symbol travels as a 1-of-4 code, meaning exactly one of four wires is high. The all-low state is the spacer between symbols. Both sides of the stage use a four-phase return-to-zero handshake:

1. A code appears on the wires.
2. The receiver raises its acknowledge.
3. The code drops back to the spacer.
4. The acknowledge falls.

The stage is built so that short spurious pulses on any wire cannot create, corrupt or drop a symbol. It has three defences:

- **Pulse filter.** Every incoming wire passes through a filter. This covers the four code wires and the downstream acknowledge. A wire's new level is taken only after it has been sampled unchanged `FILTER_LEN` times in a row.
- **Upstream lockout.** Once a symbol is stored, the stage ignores the input code wires. It only waits for them to return to the spacer.
- **Downstream window.** The downstream acknowledge is acted on only while a stored symbol is being offered.

All outputs come from registers. A disturbance on the output wires therefore cannot reach the internal state.

A filtered input with two or more wires high is illegal. It raises an error flag and is never forwarded.

Top module: `glitch_guard_stage`

## Requirements
- R1: A synchronous active-high reset drives all of these to zero: `out_code`, `in_ack` and `err_flag`.
- R2: A level on any input code wire, or on `out_ack`, takes effect only after it has been sampled at the same value for `FILTER_LEN` consecutive clock edges. A pulse of `FILTER_LEN-1` samples or fewer has no effect on any output.
- R3: A filtered input with exactly one wire high is captured. `out_code` then shows that same single wire high, with bit i meaning symbol i. `out_code` never has more than one bit set. `out_code` is non-zero only while `in_ack` is high.
- R4: In the idle state, a filtered input with two or more wires high has three results:
  - `err_flag` is set.
  - Nothing is forwarded.
  - `in_ack` stays low.

  The flag clears once the filtered input returns to all-low.
- R5: After a capture, `in_ack` stays high and further input changes are ignored. `in_ack` falls only after three things have happened: a filtered downstream acknowledge was seen, and then both the filtered input and the filtered `out_ack` are low.
- R6: A filtered `out_ack` has no effect while no symbol is stored. A new capture is held off while the filtered `out_ack` is high. A non-zero `out_code` holds its value until it returns to zero.
- R7: `out_code` returns to all-low only after the filtered `out_ack` is high. The next symbol is not emitted until `out_ack` has been filtered low.
- R8: With single-cycle glitches injected on random input code wires and on `out_ack`, the output symbol sequence equals the input sequence. No symbol is extra, missing or altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_code | input | CODE_W | 1-of-4 code wires from upstream |
| in_ack | output | 1 | Acknowledge to upstream |
| out_code | output | CODE_W | Buffered 1-of-4 code wires to downstream |
| out_ack | input | 1 | Acknowledge from downstream |
| err_flag | output | 1 | Filtered input has more than one wire high |

## Verification
The bound checker watches the following on every cycle:
- the output code is one-hot or all-low, and is paired with a raised upstream acknowledge;
- the output code never changes while it is non-zero;
- the output code falls only behind a filtered downstream acknowledge;
- the upstream acknowledge falls only after both filtered sides have reached their spacer;
- the error flag excludes forwarding.

Only the bench's scenarios can show the rest. These are the filter threshold at exactly `FILTER_LEN-1` versus `FILTER_LEN` samples, and the lockout against a different wire rising mid-handshake. They also cover the hold-off of a capture under a stuck-high downstream acknowledge, and the end-to-end symbol order under random glitch injection.

// File: rtl/gg_pkg.sv
package gg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RTZ  = 2'd2
  } gg_state_e;
endpackage

// File: rtl/gg_deglitch.sv
// One wire of pulse filtering: a new level is adopted after FILTER_LEN
// consecutive samples at that level.
module gg_deglitch #(
  parameter int FILTER_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(FILTER_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(FILTER_LEN - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      run_q <= '0;
    end else if (raw == level) begin
      run_q <= '0;
    end else if (run_q == LIM) begin
      level <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/gg_ctrl.sv
// Handshake controller: capture window, upstream lockout, downstream window.
module gg_ctrl
  import gg_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int SYM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_f,
  input  logic              ack_f,
  output gg_state_e         state_q,
  output logic [SYM_W-1:0]  sym_q,
  output logic              err_q
);
  localparam int CNT_W = $clog2(CODE_W + 1);

  logic [CNT_W-1:0] hot_cnt;
  logic [SYM_W-1:0] hot_idx;

  always_comb begin
    hot_cnt = '0;
    hot_idx = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (code_f[i]) begin
        hot_cnt = hot_cnt + 1'b1;
        hot_idx = SYM_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sym_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (hot_cnt > CNT_W'(1)) begin
            err_q <= 1'b1;
          end else if (hot_cnt == CNT_W'(1)) begin
            if (!ack_f && !err_q) begin
              sym_q   <= hot_idx;
              state_q <= ST_SEND;
            end
          end else begin
            err_q <= 1'b0;
          end
        end
        ST_SEND: begin
          if (ack_f) state_q <= ST_RTZ;
        end
        ST_RTZ: begin
          if (!ack_f && (code_f == '0)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gg_outbuf.sv
// Registered output drivers; nothing here feeds back into the controller.
module gg_outbuf
  import gg_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int SYM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  gg_state_e         state_q,
  input  logic [SYM_W-1:0]  sym_q,
  input  logic              err_q,
  output logic [CODE_W-1:0] out_code,
  output logic              in_ack,
  output logic              err_flag
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_wire
    always_ff @(posedge clk) begin
      if (rst) out_code[i] <= 1'b0;
      else     out_code[i] <= (state_q == ST_SEND) && (sym_q == SYM_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ack   <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      in_ack   <= (state_q != ST_IDLE);
      err_flag <= err_q;
    end
  end
endmodule

// File: rtl/glitch_guard_stage.sv
module glitch_guard_stage
  import gg_pkg::*;
#(
  parameter int FILTER_LEN = 3,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ack,
  output logic [CODE_W-1:0] out_code,
  input  logic              out_ack,
  output logic              err_flag
);
  localparam int SYM_W = $clog2(CODE_W);

  logic [CODE_W-1:0] code_f;
  logic              ack_f;
  gg_state_e         state_q;
  logic [SYM_W-1:0]  sym_q;
  logic              err_q;

  for (genvar i = 0; i < CODE_W; i++) begin : g_in_filt
    gg_deglitch #(.FILTER_LEN(FILTER_LEN)) u_flt (
      .clk(clk), .rst(rst), .raw(in_code[i]), .level(code_f[i])
    );
  end

  gg_deglitch #(.FILTER_LEN(FILTER_LEN)) u_ack_flt (
    .clk(clk), .rst(rst), .raw(out_ack), .level(ack_f)
  );

  gg_ctrl #(.CODE_W(CODE_W), .SYM_W(SYM_W)) u_ctrl (
    .clk(clk), .rst(rst), .code_f(code_f), .ack_f(ack_f),
    .state_q(state_q), .sym_q(sym_q), .err_q(err_q)
  );

  gg_outbuf #(.CODE_W(CODE_W), .SYM_W(SYM_W)) u_obuf (
    .clk(clk), .rst(rst), .state_q(state_q), .sym_q(sym_q), .err_q(err_q),
    .out_code(out_code), .in_ack(in_ack), .err_flag(err_flag)
  );
endmodule

// File: rtl/gg_stage_checker.sv
module gg_stage_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] in_code,
  input logic              in_ack,
  input logic [CODE_W-1:0] out_code,
  input logic              out_ack,
  input logic              err_flag,
  input logic [CODE_W-1:0] code_f,
  input logic              ack_f
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_code == '0 && !in_ack && !err_flag));

  a_r3_onehot_out: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_code));

  a_r3_code_with_ack: assert property (@(posedge clk) disable iff (rst)
    (out_code != '0) |-> in_ack);

  a_r4_err_blocks: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (out_code == '0 && !in_ack));

  a_r5_ack_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ack) |-> ($past(code_f) == '0 && !$past(ack_f)));

  a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
    (out_code != '0) |=> (out_code == '0 || $stable(out_code)));

  a_r7_rtz_after_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(|out_code) |-> $past(ack_f));
endmodule

bind glitch_guard_stage gg_stage_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .in_code(in_code), .in_ack(in_ack),
  .out_code(out_code), .out_ack(out_ack), .err_flag(err_flag),
  .code_f(code_f), .ack_f(ack_f)
);

// File: tb/tb_glitch_guard_stage.sv
`timescale 1ns/1ps
module tb_glitch_guard_stage;
  localparam int FL = 3;
  localparam int CW = 4;
  localparam int NSYM = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] p_code = '0, g_code = '0;
  logic ack_man = 1'b0, cons_ack = 1'b0, g_ack = 1'b0;
  logic cons_en = 1'b0, glitch_en = 1'b0;
  logic in_ack, err_flag;
  logic [CW-1:0] out_code;

  int vecs = 0, miss = 0;
  int tx [NSYM];
  int rx [256];
  int nrx = 0;
  int gcyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  glitch_guard_stage #(.FILTER_LEN(FL), .CODE_W(CW)) dut (
    .clk(clk), .rst(rst), .in_code(p_code | g_code), .in_ack(in_ack),
    .out_code(out_code), .out_ack(cons_ack | ack_man | g_ack),
    .err_flag(err_flag)
  );

  function automatic int code2sym(input logic [CW-1:0] c);
    int s = -1;
    for (int i = 0; i < CW; i++) if (c[i]) s = (s == -1) ? i : 99;
    return s;
  endfunction

  function automatic logic [CW-1:0] sym2code(input int s);
    return CW'(1) << s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack(input logic lvl, output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      if (in_ack === lvl) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_out_zero(output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      if (out_code === '0) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  // Finish a handshake by hand when the automatic consumer is off.
  task automatic manual_drain(input string tag);
    bit ok;
    ack_man = 1'b1;
    wait_out_zero(ok);
    chk(ok, tag, out_code, 0);
    p_code = '0;
    cyc(2 * FL + 4);
    chk(in_ack === 1'b1, {tag, " ack held while downstream ack high"}, in_ack, 1);
    ack_man = 1'b0;
    wait_ack(1'b0, ok);
    chk(ok, {tag, " in_ack fall"}, in_ack, 0);
  endtask

  // Consumer: raises its acknowledge after a code appears, records the symbol.
  always @(negedge clk) begin
    if (cons_en) begin
      if (out_code != '0 && !cons_ack) begin
        if ($urandom % 3 != 0) begin
          if (nrx < 256) rx[nrx] = code2sym(out_code);
          nrx++;
          cons_ack = 1'b1;
        end
      end else if (out_code == '0 && cons_ack) begin
        cons_ack = 1'b0;
      end
    end
  end

  // Glitch injector: single-cycle pulses, at most one every four cycles.
  always @(negedge clk) begin
    g_code = '0;
    g_ack  = 1'b0;
    gcyc++;
    if (glitch_en && (gcyc % 4 == 0) && ($urandom % 2 == 1)) begin
      int w;
      w = int'($urandom % 5);
      if (w < CW) g_code[w] = 1'b1;
      else        g_ack = 1'b1;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'd2024));
    cyc(5);
    chk(out_code === '0, "R1 out_code reset", out_code, 0);
    chk(in_ack === 1'b0, "R1 in_ack reset", in_ack, 0);
    chk(err_flag === 1'b0, "R1 err_flag reset", err_flag, 0);
    rst = 1'b0;
    cyc(2);
    chk(out_code === '0 && in_ack === 1'b0, "R1 idle after release", in_ack, 0);

    // R2: pulse one sample too short is ignored
    p_code = 4'b1000;
    cyc(FL - 1);
    p_code = '0;
    ok = 1;
    for (int i = 0; i < 4 * FL + 4; i++) begin
      if (in_ack !== 1'b0 || out_code !== '0) ok = 0;
      cyc(1);
    end
    chk(ok, "R2 short input pulse ignored", in_ack, 0);

    // R2: pulse of exactly FILTER_LEN samples is a symbol
    p_code = 4'b1000;
    cyc(FL);
    p_code = '0;
    wait_ack(1'b1, ok);
    chk(ok, "R2 full-width pulse accepted", in_ack, 1);
    chk(out_code === 4'b1000, "R3 captured code", out_code, 8);
    manual_drain("R7 drain after R2");

    // R5/R6: lockout and short ack pulse during send
    p_code = 4'b0001;
    wait_ack(1'b1, ok);
    chk(ok && out_code === 4'b0001, "R3 symbol 0 forwarded", out_code, 1);
    p_code = 4'b0100;
    cyc(6 * FL);
    chk(out_code === 4'b0001, "R5 input change locked out", out_code, 1);
    ack_man = 1'b1;
    cyc(FL - 1);
    ack_man = 1'b0;
    cyc(4 * FL);
    chk(out_code === 4'b0001, "R2 short downstream ack ignored", out_code, 1);
    p_code = '0;
    cyc(4 * FL);
    chk(in_ack === 1'b1, "R5 ack held without downstream ack", in_ack, 1);
    manual_drain("R7 drain after R5");

    // R6: long downstream ack while idle holds off capture
    ack_man = 1'b1;
    cyc(4 * FL);
    chk(out_code === '0 && in_ack === 1'b0, "R6 idle ack no effect", out_code, 0);
    p_code = 4'b0010;
    cyc(6 * FL);
    chk(in_ack === 1'b0, "R6 capture held off by high ack", in_ack, 0);
    ack_man = 1'b0;
    wait_ack(1'b1, ok);
    chk(ok && out_code === 4'b0010, "R6 capture after ack release", out_code, 2);
    manual_drain("R7 drain after R6");

    // R4: two-hot input
    p_code = 4'b0011;
    cyc(4 * FL);
    chk(err_flag === 1'b1, "R4 err on two-hot", err_flag, 1);
    chk(out_code === '0 && in_ack === 1'b0, "R4 two-hot not forwarded", out_code, 0);
    p_code = '0;
    cyc(4 * FL);
    chk(err_flag === 1'b0, "R4 err clears on spacer", err_flag, 0);
    chk(in_ack === 1'b0, "R4 still idle", in_ack, 0);

    // R8: random symbols under glitches
    nrx = 0;
    cons_en = 1'b1;
    glitch_en = 1'b1;
    for (int k = 0; k < NSYM; k++) begin
      tx[k] = int'($urandom % CW);
      wait_ack(1'b0, ok);
      if (!ok) chk(0, "R8 producer wait idle", in_ack, 0);
      p_code = sym2code(tx[k]);
      wait_ack(1'b1, ok);
      if (!ok) chk(0, "R8 producer wait ack", in_ack, 1);
      cyc($urandom % 3);
      p_code = '0;
    end
    wait_ack(1'b0, ok);
    cyc(20);
    glitch_en = 1'b0;
    chk(nrx == NSYM, "R8 symbol count", nrx, NSYM);
    for (int k = 0; k < NSYM && k < nrx; k++)
      chk(rx[k] == tx[k], "R8 symbol value", rx[k], tx[k]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule